// File: doc/BRIEF.md
# Keyed Clock-Control Register Guard

This block holds a 16-bit clock-control register behind a write guard, so that a stray store cannot retarget the clock or start a switch by mistake. Software reaches the register over a byte-wide write port. A write takes effect only in a cycle where the instruction-slot strobe is high. The upper byte carries a new-oscillator selection field. The lower byte carries a switch-enable bit and a read-only lock flag.

Each byte has its own two-value key. Software must write the two key values to that byte in two back-to-back instructions. Only the instruction that follows the key may change the byte, and the key writes never change the register themselves. When software sets the enable bit, the block sends a one-cycle request to the clock switcher. The switcher clears the bit again through a done input. The lock flag follows an external PLL-locked signal, so software can tell why a switch has not finished.

Top module: `keyunlk_top`

## Requirements
- R1: After synchronous reset, `ctrl_reg` reads all zeros and `switch_req` is low.
- R2: Two slots in a row with writes of 0x78 and then 0x9A to the upper byte (address 1) open the upper byte for the next slot only. A write to address 1 in that slot loads `wr_data[2:0]` into the selection field, `ctrl_reg[10:8]`.
- R3: Two slots in a row with writes of 0x46 and then 0x57 to the lower byte (address 0) open the lower byte for the next slot only. A write to address 0 in that slot loads `wr_data[0]` into the enable bit, `ctrl_reg[0]`.
- R4: A byte's key progress drops back to idle on any of these: a slot without a write to that byte, a wrong key value, or a key value written to another address. The write that follows is then ignored.
- R5: The open window covers exactly one slot. Once that slot has passed, a write to the byte is ignored until the full key is given again.
- R6: Key writes and writes to a closed byte leave the register unchanged. Cycles with `instr_slot` low are not instructions: any write in them is ignored, and they neither advance nor reset key progress.
- R7: `switch_req` is high for exactly one cycle, in the cycle in which the enable bit first reads 1 after a guarded write that sets it.
- R8: `switch_done` clears a set enable bit at the next edge. In the same cycle, it takes priority over a guarded write to the lower byte.
- R9: The lock flag `ctrl_reg[5]` shows `pll_locked` as registered one cycle earlier. Writes never affect it.
- R10: Upper-byte bits 15:11 and lower-byte bits 7:6 and 4:1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_slot | input | 1 | High in a cycle that completes one instruction |
| wr_en | input | 1 | Write strobe, used only when `instr_slot` is high |
| wr_addr | input | 4 | Byte address: 0 is the lower byte, 1 is the upper byte |
| wr_data | input | 8 | Write data byte |
| switch_done | input | 1 | Clock switcher finished; clears the enable bit |
| pll_locked | input | 1 | PLL lock indication, copied into the lock flag |
| ctrl_reg | output | 16 | Guarded register contents |
| switch_req | output | 1 | One-cycle request to start a clock switch |

## Verification
The embedded assertions check the following on every cycle:
- The selection field changes only after an accepted upper-byte write, and the enable bit rises only after an accepted lower-byte write.
- An open window closes after one slot, and key progress is unchanged when `instr_slot` is low.
- The request is a single-cycle pulse that coincides with a set enable bit.
- `switch_done` clears the enable bit.
- The lock flag trails `pll_locked` by one cycle.

Some behaviour only the bench scenarios can show:
- A correct key does open the byte.
- The window is exactly one slot after the key.
- A wrong value, a wrong address or a gap in the slots kills the key.
- Gaps with `instr_slot` low are tolerated.
- The done input wins over a write in the same cycle.

These scenarios are checked against a reference model over directed and seeded random traffic.

// File: rtl/keyunlk_pkg.sv
package keyunlk_pkg;
  typedef enum logic [1:0] {
    TRK_IDLE = 2'd0,
    TRK_HALF = 2'd1,
    TRK_OPEN = 2'd2
  } trk_e;
endpackage

// File: rtl/keyunlk_tracker.sv
module keyunlk_tracker
  import keyunlk_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int MY_ADDR = 0,
  parameter logic [DATA_W-1:0] KEY_A = '0,
  parameter logic [DATA_W-1:0] KEY_B = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_slot,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              accept_o
);
  localparam logic [ADDR_W-1:0] ADDR_V = ADDR_W'(MY_ADDR);

  trk_e st_q, st_d;
  logic hit;

  assign hit      = instr_slot && wr_en && (wr_addr == ADDR_V);
  assign accept_o = (st_q == TRK_OPEN) && hit;

  always_comb begin
    st_d = st_q;
    if (instr_slot) begin
      unique case (st_q)
        TRK_IDLE: st_d = (hit && wr_data == KEY_A) ? TRK_HALF : TRK_IDLE;
        TRK_HALF: st_d = (hit && wr_data == KEY_B) ? TRK_OPEN : TRK_IDLE;
        default:  st_d = TRK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= TRK_IDLE;
    else     st_q <= st_d;
  end

  // R5
  window_once_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_slot && st_q == TRK_OPEN) |=> (st_q == TRK_IDLE));

  // R6
  idle_cycle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!instr_slot) |=> $stable(st_q));
endmodule

// File: rtl/keyunlk_fields.sv
module keyunlk_fields #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hi_acc,
  input  logic              lo_acc,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              switch_done,
  input  logic              pll_locked,
  output logic [SEL_W-1:0]  sel_q,
  output logic              en_q,
  output logic              lock_q,
  output logic              req_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      en_q   <= 1'b0;
      lock_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      lock_q <= pll_locked;
      req_q  <= 1'b0;
      if (hi_acc) sel_q <= wr_data[SEL_W-1:0];
      if (switch_done && en_q) begin
        en_q <= 1'b0;
      end else if (lo_acc) begin
        en_q  <= wr_data[0];
        req_q <= wr_data[0] && !en_q;
      end
    end
  end

  // R7
  req_single_chk: assert property (@(posedge clk) disable iff (rst)
    req_q |=> !req_q);

  // R7
  req_with_en_chk: assert property (@(posedge clk) disable iff (rst)
    req_q |-> en_q);

  // R8
  done_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (switch_done && en_q) |=> !en_q);

  // R9
  lock_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (lock_q == $past(pll_locked)));
endmodule

// File: rtl/keyunlk_top.sv
module keyunlk_top #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int SEL_W    = 3,
  parameter int LOCK_BIT = 5,
  parameter int LO_ADDR  = 0,
  parameter int HI_ADDR  = 1,
  parameter logic [DATA_W-1:0] HI_KEY_A = 8'h78,
  parameter logic [DATA_W-1:0] HI_KEY_B = 8'h9A,
  parameter logic [DATA_W-1:0] LO_KEY_A = 8'h46,
  parameter logic [DATA_W-1:0] LO_KEY_B = 8'h57
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                instr_slot,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                switch_done,
  input  logic                pll_locked,
  output logic [2*DATA_W-1:0] ctrl_reg,
  output logic                switch_req
);
  localparam int NBYTE = 2;

  logic [NBYTE-1:0] acc;
  logic [SEL_W-1:0] sel_q;
  logic             en_q;
  logic             lock_q;
  logic [DATA_W-1:0] lo_byte;

  // index 0 guards the lower byte, index 1 the upper byte
  for (genvar g = 0; g < NBYTE; g++) begin : g_trk
    keyunlk_tracker #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .MY_ADDR(g == 0 ? LO_ADDR : HI_ADDR),
      .KEY_A  (g == 0 ? LO_KEY_A : HI_KEY_A),
      .KEY_B  (g == 0 ? LO_KEY_B : HI_KEY_B)
    ) u_trk (
      .clk       (clk),
      .rst       (rst),
      .instr_slot(instr_slot),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .accept_o  (acc[g])
    );
  end

  keyunlk_fields #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_fields (
    .clk        (clk),
    .rst        (rst),
    .hi_acc     (acc[1]),
    .lo_acc     (acc[0]),
    .wr_data    (wr_data),
    .switch_done(switch_done),
    .pll_locked (pll_locked),
    .sel_q      (sel_q),
    .en_q       (en_q),
    .lock_q     (lock_q),
    .req_q      (switch_req)
  );

  always_comb begin
    lo_byte           = '0;
    lo_byte[0]        = en_q;
    lo_byte[LOCK_BIT] = lock_q;
  end

  assign ctrl_reg = {{(DATA_W-SEL_W){1'b0}}, sel_q, lo_byte};

  // R2
  hi_guard_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel_q) |-> $past(acc[1]));

  // R3
  en_guard_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(en_q) |-> $past(acc[0]));

  // R4
  one_byte_chk: assert property (@(posedge clk) disable iff (rst)
    !(acc[0] && acc[1]));
endmodule

// File: tb/tb_keyunlk_top.sv
module tb_keyunlk_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_slot = 1'b0, wr_en = 1'b0, switch_done = 1'b0, pll_locked = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] ctrl_reg;
  logic        switch_req;

  int errors = 0, checks = 0;
  int m_hst = 0, m_lst = 0;
  logic [2:0] m_sel = '0;
  logic m_en = 1'b0, m_lock = 1'b0, m_req = 1'b0;

  always #2 clk = ~clk;

  keyunlk_top dut (.*);

  function automatic int nxt(int st, bit hit, logic [7:0] d, logic [7:0] ka, logic [7:0] kb, bit slot);
    if (!slot) return st;
    if (st == 0) return (hit && d == ka) ? 1 : 0;
    if (st == 1) return (hit && d == kb) ? 2 : 0;
    return 0;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(bit slot, bit we, logic [3:0] a, logic [7:0] d, bit done, bit pll);
    bit wh, wl, ha, la;
    instr_slot = slot; wr_en = we; wr_addr = a; wr_data = d;
    switch_done = done; pll_locked = pll;
    @(posedge clk);
    if (rst) begin
      m_hst = 0; m_lst = 0; m_sel = '0; m_en = 0; m_lock = 0; m_req = 0;
    end else begin
      wh = slot && we && a == 4'd1;
      wl = slot && we && a == 4'd0;
      ha = (m_hst == 2) && wh;
      la = (m_lst == 2) && wl;
      m_hst = nxt(m_hst, wh, d, 8'h78, 8'h9A, slot);
      m_lst = nxt(m_lst, wl, d, 8'h46, 8'h57, slot);
      m_lock = pll;
      m_req = 0;
      if (ha) m_sel = d[2:0];
      if (done && m_en) m_en = 0;
      else if (la) begin
        m_req = d[0] && !m_en;
        m_en = d[0];
      end
    end
    #1;
    chk(ctrl_reg[10:8] == m_sel, "R2 sel", ctrl_reg[10:8], m_sel);
    chk(ctrl_reg[0] == m_en, "R3 en", ctrl_reg[0], m_en);
    chk(switch_req == m_req, "R7 req", switch_req, m_req);
    chk(ctrl_reg[5] == m_lock, "R9 lock", ctrl_reg[5], m_lock);
    chk((ctrl_reg & 16'hF8DE) == 0, "R10 zero bits", ctrl_reg & 16'hF8DE, 0);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    cyc(1, 1, a, d, 0, pll_locked);
  endtask

  task automatic idle_slot();
    cyc(1, 0, 0, 0, 0, pll_locked);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit s, w, dn, p;
    logic [3:0] a;
    logic [7:0] d;
    int k;
    void'($urandom(32'd1357));
    rst = 1;
    cyc(0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 1);
    // R1 reset state
    chk(ctrl_reg == 16'h0 && switch_req == 0, "R1 reset", ctrl_reg, 0);
    rst = 0;
    idle_slot();
    // R2 upper-byte unlock and load
    wr(1, 8'h78); wr(1, 8'h9A); wr(1, 8'h05);
    chk(ctrl_reg[10:8] == 3'd5, "R2 directed", ctrl_reg[10:8], 5);
    // R5 window closes after one slot
    wr(1, 8'h78); wr(1, 8'h9A); idle_slot(); wr(1, 8'h02);
    chk(ctrl_reg[10:8] == 3'd5, "R5 late write", ctrl_reg[10:8], 5);
    // R4 wrong value, wrong address, intervening slot
    wr(1, 8'h78); wr(1, 8'h9B); wr(1, 8'h03);
    wr(1, 8'h78); wr(0, 8'h9A); wr(1, 8'h03);
    wr(0, 8'h46); idle_slot(); wr(0, 8'h57); wr(0, 8'h01);
    chk(ctrl_reg[10:8] == 3'd5 && ctrl_reg[0] == 0, "R4 broken key", ctrl_reg, 16'h0500);
    // R6 non-slot cycles tolerated, ignored writes
    wr(0, 8'h46); cyc(0, 1, 0, 8'h01, 0, 0); wr(0, 8'h57);
    cyc(0, 1, 0, 8'h01, 0, 0);
    chk(ctrl_reg[0] == 0, "R6 non-slot write", ctrl_reg[0], 0);
    // R3 and R7 lower-byte unlock sets enable and pulses request
    wr(0, 8'h01);
    chk(ctrl_reg[0] == 1 && switch_req == 1, "R3 R7 set", {ctrl_reg[0], switch_req}, 3);
    idle_slot();
    chk(switch_req == 0, "R7 single pulse", switch_req, 0);
    // R8 done beats a same-cycle guarded write
    wr(0, 8'h46); wr(0, 8'h57);
    cyc(1, 1, 0, 8'h01, 1, 0);
    chk(ctrl_reg[0] == 0 && switch_req == 0, "R8 done priority", ctrl_reg[0], 0);
    // R9 lock mirror, write cannot touch it
    cyc(1, 0, 0, 0, 0, 1);
    wr(0, 8'h46); wr(0, 8'h57); wr(0, 8'h00);
    chk(ctrl_reg[5] == 1, "R9 lock held", ctrl_reg[5], 1);
    // random traffic mixed with key values
    for (int i = 0; i < 4000; i++) begin
      s = ($urandom % 10) < 8;
      w = ($urandom % 10) < 7;
      a = 4'($urandom % 3);
      k = $urandom % 6;
      d = (k == 0) ? 8'h78 : (k == 1) ? 8'h9A : (k == 2) ? 8'h46 :
          (k == 3) ? 8'h57 : 8'($urandom);
      dn = ($urandom % 10) == 0;
      p = (($urandom % 8) == 0) ? !pll_locked : pll_locked;
      cyc(s, w, a, d, dn, p);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule